// File: doc/BRIEF.md
# Receiver Acquisition Control Sequencer

This block sequences the acquisition phases of a packet data modem receiver. It watches four control bits: clock acquisition, I/Q DC offset acquisition, frequency (AFC) acquisition and packet-detect enable. It responds to changes in these bits, not to their levels. It drives enable strobes to the datapath units that measure and correct offsets. It also gates the RF input while a coarse offset is being measured.

A rising edge on the I/Q acquire bit starts a sequence with four phases. First the RF input is gated off. Then a coarse measurement runs with the input gated. Then the input is released. Finally the block hands over to a residual tracking mode, which a two-bit field selects. A falling edge on the same bit at any point ends the sequence early and jumps straight to tracking, with the RF input enabled. Each phase moves on when its done handshake arrives. A programmable timeout forces tracking if the handshake never comes.

The AFC sequence latches the measured frequency offset into an output register. The clock sequence counts bit-rate strobes so that the block can tell the host when it is safe to start a frame search. Transmit mode silences all of this.

Top module: `rx_acq_seq`

## Requirements
- R1: While `tx_mode` is 1, every acquire bit and the packet-detect enable are ignored. One cycle after `tx_mode` is seen high, the I/Q phase is IDLE, `rf_en` is 1, `afc_busy` and `clk_busy` are 0, and the bit counter is cleared, so `search_rdy` is 0. If an acquire bit rose during transmit and is still 1 when receive resumes, no sequence starts.
- R2: In receive mode, a 0-to-1 change of `acq_iq` moves `iq_phase` to GATE_RF (code 1) on the next cycle. Holding the bit at 1 never restarts the sequence.
- R3: The I/Q sequence runs GATE_RF (1, `rf_en`=0) on `iq_done` to COARSE_MEAS (2, `rf_en`=0, `coarse_en`=1), on `iq_done` to RELEASE_RF (3, `rf_en`=1), and on `iq_done` to TRACK (4). IDLE is code 0.
- R4: In TRACK, `track_en` is 1 and `track_mode` equals `track_sel`. In every other phase, `track_en` is 0 and `track_mode` is 0.
- R5: A 1-to-0 change of `acq_iq` during GATE_RF, COARSE_MEAS or RELEASE_RF moves the phase to TRACK on the next cycle, with `rf_en` at 1.
- R6: A phase from 1 to 3 that sees no `iq_done` stays for `timeout_lim`+1 cycles and then moves to TRACK.
- R7: A 0-to-1 change of `acq_afc` sets `afc_busy` and `afc_meas_en`. If `afc_done` arrives while busy with `acq_afc` still 1, `afc_meas_val` is loaded into `freq_ofs` and busy clears. A falling `acq_afc` clears busy and leaves `freq_ofs` unchanged.
- R8: `pkt_likely` equals `likely_data` when `pkt_det_en` is 1 in receive mode, and is 0 otherwise.
- R9: A 0-to-1 change of `acq_clk` clears and starts a bit counter that counts `bit_stb` pulses up to NBITS (12). `search_rdy` is 1 only when the count has reached 12 and `iq_phase` is TRACK.
- R10: A synchronous reset gives phase IDLE, `rf_en`=1, no busy flags, `freq_ofs`=0 and a cleared bit counter.
- R11: A 0-to-1 change of `acq_clk` sets `clk_busy` and `clk_acq_en`. `clk_done` clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_mode | input | 1 | 1 = transmit, 0 = receive |
| acq_clk | input | 1 | Clock acquisition request bit |
| acq_iq | input | 1 | I/Q offset acquisition request bit |
| acq_afc | input | 1 | AFC acquisition request bit |
| pkt_det_en | input | 1 | Packet-detect enable |
| track_sel | input | 2 | Residual tracking mode field |
| timeout_lim | input | TMO_W | Per-phase timeout limit |
| bit_stb | input | 1 | Bit-rate strobe |
| iq_done | input | 1 | I/Q phase done handshake |
| afc_done | input | 1 | AFC measurement done |
| clk_done | input | 1 | Clock acquisition done |
| likely_data | input | 1 | Demodulator valid-data indication |
| afc_meas_val | input | FOFS_W | Measured frequency offset |
| iq_phase | output | 3 | Current I/Q phase code |
| rf_en | output | 1 | RF input enable |
| coarse_en | output | 1 | Coarse offset measurement enable |
| track_en | output | 1 | Residual tracking active |
| track_mode | output | 2 | Active tracking mode |
| iq_busy | output | 1 | I/Q sequence in progress |
| afc_busy | output | 1 | AFC sequence in progress |
| afc_meas_en | output | 1 | AFC measurement enable |
| clk_busy | output | 1 | Clock acquisition in progress |
| clk_acq_en | output | 1 | Clock acquisition enable |
| freq_ofs | output | FOFS_W | Frequency offset result register |
| pkt_likely | output | 1 | Status bit 0: likely valid data |
| search_rdy | output | 1 | Frame search may start |

## Verification
The assertions check several rules on every cycle:
- the transmit-mode shutdown;
- the entry into GATE_RF on a rising edge;
- the fixed order in which COARSE_MEAS and RELEASE_RF are entered;
- the jump to TRACK on an abort or a timeout;
- the capture of the AFC result;
- the clearing of the clock busy flag.

Some behaviour only the bench's scenarios can show. These scenarios cover:
- the mapping of every tracking field value;
- the exact dwell lengths for a range of timeout limits in each phase;
- the full truth table of the packet status bit;
- the exact strobe count at which frame search becomes ready;
- the fact that a request raised during transmit stays inert once receive resumes.

// File: rtl/rx_acq_seq.sv
module rx_acq_seq #(
  parameter int TMO_W  = 8,
  parameter int FOFS_W = 12,
  parameter int NBITS  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_mode,
  input  logic              acq_clk,
  input  logic              acq_iq,
  input  logic              acq_afc,
  input  logic              pkt_det_en,
  input  logic [1:0]        track_sel,
  input  logic [TMO_W-1:0]  timeout_lim,
  input  logic              bit_stb,
  input  logic              iq_done,
  input  logic              afc_done,
  input  logic              clk_done,
  input  logic              likely_data,
  input  logic [FOFS_W-1:0] afc_meas_val,
  output logic [2:0]        iq_phase,
  output logic              rf_en,
  output logic              coarse_en,
  output logic              track_en,
  output logic [1:0]        track_mode,
  output logic              iq_busy,
  output logic              afc_busy,
  output logic              afc_meas_en,
  output logic              clk_busy,
  output logic              clk_acq_en,
  output logic [FOFS_W-1:0] freq_ofs,
  output logic              pkt_likely,
  output logic              search_rdy
);

  localparam int CNT_W = $clog2(NBITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(NBITS);

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_GATE   = 3'd1,
    PH_COARSE = 3'd2,
    PH_REL    = 3'd3,
    PH_TRACK  = 3'd4
  } phase_t;

  phase_t            phase, phase_n;
  logic              iq_q, afc_q, clk_q;
  logic [TMO_W-1:0]  tmo_cnt;
  logic [CNT_W-1:0]  bit_cnt;
  logic              cnt_run;

  wire rx       = ~tx_mode;
  wire iq_rise  = rx & acq_iq  & ~iq_q;
  wire iq_fall  = rx & ~acq_iq & iq_q;
  wire afc_rise = rx & acq_afc & ~afc_q;
  wire afc_fall = rx & ~acq_afc & afc_q;
  wire clk_rise = rx & acq_clk & ~clk_q;
  wire clk_fall = rx & ~acq_clk & clk_q;
  wire active   = (phase == PH_GATE) | (phase == PH_COARSE) | (phase == PH_REL);
  wire tmo_hit  = active & ~iq_done & (tmo_cnt == timeout_lim);

  always_comb begin
    phase_n = phase;
    if (tx_mode)                phase_n = PH_IDLE;
    else if (iq_rise)           phase_n = PH_GATE;
    else if (iq_fall && active) phase_n = PH_TRACK;
    else if (tmo_hit)           phase_n = PH_TRACK;
    else if (iq_done) begin
      case (phase)
        PH_GATE:   phase_n = PH_COARSE;
        PH_COARSE: phase_n = PH_REL;
        PH_REL:    phase_n = PH_TRACK;
        default:   phase_n = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      tmo_cnt <= '0;
      iq_q    <= 1'b0;
      afc_q   <= 1'b0;
      clk_q   <= 1'b0;
    end else begin
      phase <= phase_n;
      iq_q  <= acq_iq;
      afc_q <= acq_afc;
      clk_q <= acq_clk;
      if (phase_n != phase || !active) tmo_cnt <= '0;
      else                             tmo_cnt <= tmo_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      afc_busy <= 1'b0;
      freq_ofs <= '0;
    end else if (tx_mode) begin
      afc_busy <= 1'b0;
    end else if (afc_rise) begin
      afc_busy <= 1'b1;
    end else if (afc_fall) begin
      afc_busy <= 1'b0;
    end else if (afc_busy && afc_done) begin
      afc_busy <= 1'b0;
      freq_ofs <= afc_meas_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tx_mode) begin
      clk_busy <= 1'b0;
      cnt_run  <= 1'b0;
      bit_cnt  <= '0;
    end else if (clk_rise) begin
      clk_busy <= 1'b1;
      cnt_run  <= 1'b1;
      bit_cnt  <= '0;
    end else begin
      if (clk_fall || clk_done) clk_busy <= 1'b0;
      if (cnt_run && bit_stb && bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign iq_phase    = phase;
  assign iq_busy     = active;
  assign rf_en       = ~((phase == PH_GATE) | (phase == PH_COARSE));
  assign coarse_en   = (phase == PH_COARSE);
  assign track_en    = (phase == PH_TRACK);
  assign track_mode  = track_en ? track_sel : 2'b00;
  assign afc_meas_en = afc_busy;
  assign clk_acq_en  = clk_busy;
  assign pkt_likely  = rx & pkt_det_en & likely_data;
  assign search_rdy  = rx & cnt_run & (bit_cnt == CNT_MAX) & (phase == PH_TRACK);

  assert_tx_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    tx_mode |=> (iq_phase == 3'd0 && rf_en && !afc_busy && !clk_busy && !search_rdy));

  assert_iq_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!tx_mode && acq_iq && !iq_q) |=> (iq_phase == 3'd1 && !rf_en));

  assert_coarse_order_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COARSE && !$stable(phase)) |-> $past(phase) == PH_GATE);

  assert_release_order_R3: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_REL && !$stable(phase)) |-> $past(phase) == PH_COARSE);

  assert_abort_R5: assert property (@(posedge clk) disable iff (rst)
    (!tx_mode && !acq_iq && iq_q && iq_busy) |=> (track_en && rf_en));

  assert_timeout_R6: assert property (@(posedge clk) disable iff (rst)
    (!tx_mode && iq_busy && !iq_done && tmo_cnt == timeout_lim && !(acq_iq ^ iq_q))
      |=> iq_phase == 3'd4);

  assert_afc_capture_R7: assert property (@(posedge clk) disable iff (rst)
    (!tx_mode && afc_busy && afc_done && acq_afc)
      |=> (freq_ofs == $past(afc_meas_val) && !afc_busy));

  assert_clk_done_R11: assert property (@(posedge clk) disable iff (rst)
    (!tx_mode && clk_busy && clk_done && acq_clk) |=> !clk_busy);

endmodule

// File: tb/rx_acq_seq_bench.sv
module rx_acq_seq_bench;
  localparam int TMO_W = 4;
  localparam int FW    = 12;

  logic clk = 1'b0, rst = 1'b1;
  logic tx_mode = 0, acq_clk = 0, acq_iq = 0, acq_afc = 0, pkt_det_en = 0;
  logic [1:0] track_sel = 0;
  logic [TMO_W-1:0] timeout_lim = 4'd15;
  logic bit_stb = 0, iq_done = 0, afc_done = 0, clk_done = 0, likely_data = 0;
  logic [FW-1:0] afc_meas_val = 0;
  logic [2:0] iq_phase;
  logic rf_en, coarse_en, track_en, iq_busy, afc_busy, afc_meas_en, clk_busy, clk_acq_en;
  logic [1:0] track_mode;
  logic [FW-1:0] freq_ofs;
  logic pkt_likely, search_rdy;

  int checks = 0, failures = 0, cycles = 0;

  always #2.5 clk = ~clk;

  rx_acq_seq #(.TMO_W(TMO_W), .FOFS_W(FW), .NBITS(12)) u_rx_acq_seq (
    .clk, .rst, .tx_mode, .acq_clk, .acq_iq, .acq_afc, .pkt_det_en, .track_sel,
    .timeout_lim, .bit_stb, .iq_done, .afc_done, .clk_done, .likely_data, .afc_meas_val,
    .iq_phase, .rf_en, .coarse_en, .track_en, .track_mode, .iq_busy, .afc_busy,
    .afc_meas_en, .clk_busy, .clk_acq_en, .freq_ofs, .pkt_likely, .search_rdy);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic pulse_done;
    iq_done = 1; step(); iq_done = 0;
  endtask

  task automatic start_to(input int p);
    acq_iq = 1; step();
    for (int k = 1; k < p; k++) pulse_done();
  endtask

  task automatic leave_track;
    acq_iq = 0; step();
  endtask

  initial begin
    while (1) begin
      @(posedge clk); cycles++;
      if (cycles > 100000) begin
        checks++; failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    step(3);
    rst = 0;
    chk("R10 phase", iq_phase, 0);
    chk("R10 rf_en", rf_en, 1);
    chk("R10 busy", {iq_busy, afc_busy, clk_busy}, 0);
    chk("R10 freq", freq_ofs, 0);
    chk("R10 rdy", search_rdy, 0);

    // R2 R3 R4: full sequence for every tracking field value
    for (int s = 0; s < 4; s++) begin
      track_sel = 2'(s);
      acq_iq = 1; step();
      chk("R2 gate", iq_phase, 1);
      chk("R3 gate rf", {rf_en, coarse_en, track_en}, 3'b000);
      step(2);
      chk("R2 hold no restart", iq_phase, 1);
      iq_done = 1; step();
      chk("R3 coarse", {iq_phase, rf_en, coarse_en}, {3'd2, 2'b01});
      step();
      chk("R3 release", {iq_phase, rf_en, coarse_en}, {3'd3, 2'b10});
      chk("R4 no track yet", {track_en, track_mode}, 0);
      step();
      iq_done = 0;
      chk("R3 track", iq_phase, 4);
      chk("R4 track mode", {track_en, track_mode}, {1'b1, 2'(s)});
      step(2);
      chk("R2 held in track", iq_phase, 4);
      leave_track();
      chk("R5 fall in track stays", iq_phase, 4);
    end

    // R5: abort sweep
    for (int p = 1; p <= 3; p++) begin
      start_to(p);
      chk("R5 reached", iq_phase, 3'(p));
      acq_iq = 0; step();
      chk("R5 abort", {iq_phase, rf_en}, {3'd4, 1'b1});
    end

    // R6: timeout sweep
    for (int lim = 0; lim < 4; lim++) begin
      timeout_lim = 4'(lim);
      for (int p = 1; p <= 3; p++) begin
        start_to(p);
        step(lim);
        chk("R6 dwell", iq_phase, 3'(p));
        step();
        chk("R6 timeout", {iq_phase, rf_en}, {3'd4, 1'b1});
        leave_track();
      end
    end
    timeout_lim = 4'd15;

    // R1: transmit mode
    start_to(2);
    tx_mode = 1; step();
    chk("R1 tx abort", {iq_phase, rf_en}, {3'd0, 1'b1});
    acq_iq = 0; step();
    acq_iq = 1; acq_afc = 1; acq_clk = 1; step();
    chk("R1 tx ignore", {iq_phase, afc_busy, clk_busy}, 0);
    tx_mode = 0; step();
    chk("R1 no late start", {iq_phase, afc_busy, clk_busy}, 0);
    acq_iq = 0; acq_afc = 0; acq_clk = 0; step();

    // R8: packet status truth table
    for (int v = 0; v < 8; v++) begin
      {tx_mode, pkt_det_en, likely_data} = 3'(v);
      #1;
      chk("R8 status", pkt_likely, (v == 3) ? 1 : 0);
    end
    tx_mode = 0; pkt_det_en = 0; likely_data = 0; step();

    // R7: AFC capture sweep and abort
    for (int k = 0; k < 4; k++) begin
      acq_afc = 1; step();
      chk("R7 busy", {afc_busy, afc_meas_en}, 2'b11);
      afc_meas_val = 12'(k * 12'h351 + 7); afc_done = 1; step();
      afc_done = 0;
      chk("R7 capture", freq_ofs, 12'(k * 12'h351 + 7));
      chk("R7 cleared", afc_busy, 0);
      acq_afc = 0; step();
    end
    acq_afc = 1; step();
    acq_afc = 0; afc_done = 1; afc_meas_val = 12'h0AB; step();
    afc_done = 0;
    chk("R7 abort keeps", freq_ofs, 12'(3 * 12'h351 + 7));
    chk("R7 abort busy", afc_busy, 0);

    // R11 and R9
    start_to(1); iq_done = 1; step(3); iq_done = 0;
    chk("R9 iq done", iq_phase, 4);
    acq_clk = 1; step();
    chk("R11 busy", {clk_busy, clk_acq_en}, 2'b11);
    clk_done = 1; step(); clk_done = 0;
    chk("R11 cleared", clk_busy, 0);
    for (int n = 0; n <= 14; n++) begin
      chk("R9 count", search_rdy, (n >= 12) ? 1 : 0);
      bit_stb = 1; step(); bit_stb = 0;
    end
    leave_track();
    acq_iq = 1; step();
    chk("R9 needs track", search_rdy, 0);
    acq_iq = 0; step();
    chk("R9 after abort", search_rdy, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule